// File: doc/BRIEF.md
# Reset and clock start-up sequencer

This block merges three reset requests into one internal reset: a power-on request, an external active-low reset pin and a brown-out request. After the requests go away it brings the system clock up in order. A power-up delay counts ticks of a slow reference clock. An oscillator settle counter counts edges of the oscillator that is starting. A wait for PLL lock follows when the PLL is used. The clock source and the primary oscillator mode are taken from configuration inputs on every reset. They are passed on as the selection given to the clock tree.

The settle counter starts at reset release and runs in parallel with the power-up delay, so a slow crystal or PLL may still be unready when the delay ends. An optional clock monitor checks readiness at that point. If the clock is not ready, it raises a one-cycle clock-failure trap, sets a sticky flag and forces the internal fast RC clock. Without the monitor, the internal reset is released and the core sits gated, with no clock, until the clock is ready.

The sequencer has six states. ST_HOLD is reset held, with the configuration followed live. ST_PWRUP_DLY is the power-up delay. ST_OSC_SETTLE waits for the settle count. ST_PLL_WAIT waits for lock. ST_RUN has the clock enabled. ST_FALLBACK means the clock was forced to the internal fast RC. Any request from any state leads to ST_HOLD. ST_HOLD goes to ST_PWRUP_DLY when the delay is enabled. ST_HOLD and ST_PWRUP_DLY go to ST_FALLBACK when the monitor finds the clock unready at the end of the power-up phase, and otherwise to ST_OSC_SETTLE. ST_OSC_SETTLE goes to ST_PLL_WAIT or ST_RUN. ST_PLL_WAIT goes to ST_RUN. ST_RUN and ST_FALLBACK are left only by a new reset.

Top module: `rst_clk_seq`

## Requirements
- R1: Any active request (por_req high, synchronised ext_rst_n low, or bor_req high) forces rst_int high and sysclk_en low, and restarts the sequence. rst_cause reports the last request seen, with priority power-on > brown-out > pin. The encodings are 2'b01 power-on, 2'b11 brown-out and 2'b10 external pin.
- R2: ext_rst_n passes through a two-flop synchroniser that is held inactive (high) during power-on. rst_int rises on the third rising clock edge after the pin falls, and falls on the third edge after the pin rises (with the power-up delay and the monitor disabled).
- R3: With cfg_pwrup_dly_en=1, rst_int stays high until PWRUP_TICKS pulses of lprc_tick have been counted after the requests are removed.
- R4: With cfg_pwrup_dly_en=0 and cfg_monitor_en=0, rst_int falls on the first rising clock edge after the last request is removed.
- R5: cfg_src values 3'b000 (internal fast RC), 3'b001 (internal low-power RC), 3'b010 (external RC) and 3'b011 (external clock) are active at once and skip the settle count. Values with bit 2 set are crystal modes and need OSC_EDGES osc_edge pulses. cfg_pmode[4]=1 means the PLL is used.
- R6: With the monitor off, sysclk_en stays low after reset release until the settle count is complete (crystal modes), and then until pll_lock is 1 (PLL used).
- R7: With cfg_monitor_en=1, if at the end of the power-up phase the clock is not ready (oscillator not running, settle count not complete in a crystal mode, or PLL used and not locked), the block pulses clk_fail_trap for exactly one cycle. It then drives clk_sel=3'b000, clk_mode=5'b00000, sysclk_en=1 and rst_int=0, and sets clk_fail_flag.
- R8: clk_fail_flag survives brown-out and pin resets. It is cleared by a flag_clr pulse, with effect on the next edge, and by power-on.
- R9: The configuration is sampled only while reset is held. A change of cfg_src outside reset has no effect on clk_sel until the next reset, which loads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| por_req | input | 1 | Power-on reset request, asynchronous assert |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| bor_req | input | 1 | Brown-out reset request, synchronous |
| lprc_tick | input | 1 | One-cycle tick from the slow reference clock |
| osc_edge | input | 1 | One-cycle pulse per edge of the starting oscillator |
| osc_running | input | 1 | Oscillator activity detected |
| pll_lock | input | 1 | PLL lock status |
| cfg_src | input | 3 | Clock source selection |
| cfg_pmode | input | 5 | Primary oscillator mode, bit 4 = PLL used |
| cfg_monitor_en | input | 1 | Clock monitor enable |
| cfg_pwrup_dly_en | input | 1 | Power-up delay enable |
| flag_clr | input | 1 | Write pulse clearing the clock-fail flag |
| rst_int | output | 1 | Internal reset |
| sysclk_en | output | 1 | System clock enable |
| clk_sel | output | 3 | Active clock source selection |
| clk_mode | output | 5 | Active primary oscillator mode |
| clk_fail_trap | output | 1 | One-cycle clock-failure trap |
| clk_fail_flag | output | 1 | Sticky clock-failure flag |
| rst_cause | output | 2 | Cause of the last reset |

## Verification
The sequence is run with random mixes of source, PLL use, monitor and delay enables, and an oscillator and lock that are each either ready early or late. Early against late separates the gated wait from a fallback. A monitor that is on against off separates a trap from a silent wait. A delay that is on against off separates a held reset from an immediate release. Directed runs pin down the exact release and assert edges for the pin and for brown-out. They also show that the flag survives a later reset and that configuration changes outside reset are ignored.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int unsigned SRC_W  = 3;
    localparam int unsigned MODE_W = 5;

    typedef enum logic [2:0] {
        ST_HOLD       = 3'd0,
        ST_PWRUP_DLY  = 3'd1,
        ST_OSC_SETTLE = 3'd2,
        ST_PLL_WAIT   = 3'd3,
        ST_RUN        = 3'd4,
        ST_FALLBACK   = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_POR  = 2'b01,
        CAUSE_EXT  = 2'b10,
        CAUSE_BOR  = 2'b11
    } rst_cause_t;

    localparam logic [SRC_W-1:0]  SRC_FAST_RC = '0;
    localparam logic [MODE_W-1:0] MODE_NONE   = '0;

    // crystal modes are the upper half of the source code space
    function automatic logic src_is_crystal(input logic [SRC_W-1:0] s);
        return s[SRC_W-1];
    endfunction

    function automatic logic mode_uses_pll(input logic [MODE_W-1:0] m);
        return m[MODE_W-1];
    endfunction

endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or posedge arst) begin
                    if (arst) chain[0] <= RESET_VAL;
                    else      chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge arst) begin
                    if (arst) chain[i] <= RESET_VAL;
                    else      chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rcs_tick_cnt.sv
module rcs_tick_cnt #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic arst,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    assign done = (cnt == LIM);

    always_ff @(posedge clk or posedge arst) begin
        if (arst)               cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (tick && !done) cnt <= cnt + 1'b1;
    end

    // R5: the count saturates at its limit
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (arst)
        cnt <= LIM);

    assert_cnt_clear_R1: assert property (@(posedge clk) disable iff (arst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/rcs_fsm.sv
module rcs_fsm
    import rcs_pkg::*;
(
    input  logic       clk,
    input  logic       arst,
    input  logic       req_any,
    input  logic       dly_en,
    input  logic       mon_en,
    input  logic       need_osc,
    input  logic       need_pll,
    input  logic       pwrup_done,
    input  logic       osc_done,
    input  logic       osc_running,
    input  logic       pll_lock,
    output seq_state_t state,
    output logic       trap,
    output logic       rst_int,
    output logic       sysclk_en,
    output logic       fallback,
    output logic       cnt_clr
);
    seq_state_t next;
    logic       clk_ready;

    assign clk_ready = (!need_osc || (osc_running && osc_done)) &&
                       (!need_pll || pll_lock);

    always_comb begin
        next = state;
        unique case (state)
            ST_HOLD: begin
                if (dly_en)                     next = ST_PWRUP_DLY;
                else if (mon_en && !clk_ready)  next = ST_FALLBACK;
                else                            next = ST_OSC_SETTLE;
            end
            ST_PWRUP_DLY: begin
                if (pwrup_done) begin
                    if (mon_en && !clk_ready)   next = ST_FALLBACK;
                    else                        next = ST_OSC_SETTLE;
                end
            end
            ST_OSC_SETTLE: begin
                if (!need_osc || osc_done)
                    next = need_pll ? ST_PLL_WAIT : ST_RUN;
            end
            ST_PLL_WAIT: begin
                if (pll_lock) next = ST_RUN;
            end
            ST_RUN:      next = ST_RUN;
            ST_FALLBACK: next = ST_FALLBACK;
            default:     next = ST_HOLD;
        endcase
        if (req_any) next = ST_HOLD;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state <= ST_HOLD;
            trap  <= 1'b0;
        end else begin
            state <= next;
            trap  <= (next == ST_FALLBACK) && (state != ST_FALLBACK);
        end
    end

    always_comb begin
        rst_int   = 1'b0;
        sysclk_en = 1'b0;
        fallback  = 1'b0;
        cnt_clr   = 1'b0;
        unique case (state)
            ST_HOLD: begin
                rst_int = 1'b1;
                cnt_clr = 1'b1;
            end
            ST_PWRUP_DLY:  rst_int = 1'b1;
            ST_OSC_SETTLE: ;
            ST_PLL_WAIT:   ;
            ST_RUN:        sysclk_en = 1'b1;
            ST_FALLBACK: begin
                sysclk_en = 1'b1;
                fallback  = 1'b1;
            end
            default: rst_int = 1'b1;
        endcase
    end

    assert_req_restarts_R1: assert property (@(posedge clk) disable iff (arst)
        req_any |=> (state == ST_HOLD));

    assert_dly_done_R3: assert property (@(posedge clk) disable iff (arst)
        (state == ST_OSC_SETTLE && $past(state) == ST_PWRUP_DLY) |-> $past(pwrup_done));

    assert_osc_gate_R6: assert property (@(posedge clk) disable iff (arst)
        (state != ST_OSC_SETTLE && $past(state) == ST_OSC_SETTLE && !$past(req_any))
        |-> $past(!need_osc || osc_done));

    assert_pll_gate_R6: assert property (@(posedge clk) disable iff (arst)
        (state == ST_RUN && $past(state) == ST_PLL_WAIT) |-> $past(pll_lock));

    assert_fallback_mon_R7: assert property (@(posedge clk) disable iff (arst)
        (state == ST_FALLBACK && $past(state) != ST_FALLBACK) |-> $past(mon_en));

    assert_trap_single_R7: assert property (@(posedge clk) disable iff (arst)
        trap |=> !trap);

endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
    import rcs_pkg::*;
#(
    parameter int unsigned PWRUP_TICKS = 64,
    parameter int unsigned OSC_EDGES   = 1024,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_req,
    input  logic              ext_rst_n,
    input  logic              bor_req,
    input  logic              lprc_tick,
    input  logic              osc_edge,
    input  logic              osc_running,
    input  logic              pll_lock,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic [MODE_W-1:0] cfg_pmode,
    input  logic              cfg_monitor_en,
    input  logic              cfg_pwrup_dly_en,
    input  logic              flag_clr,
    output logic              rst_int,
    output logic              sysclk_en,
    output logic [SRC_W-1:0]  clk_sel,
    output logic [MODE_W-1:0] clk_mode,
    output logic              clk_fail_trap,
    output logic              clk_fail_flag,
    output logic [1:0]        rst_cause
);
    logic              pin_sync;
    logic              ext_req;
    logic              req_any;
    logic              pwrup_done;
    logic              osc_done;
    logic              fallback;
    logic              cnt_clr;
    seq_state_t        state;
    rst_cause_t        cause_q;

    logic [SRC_W-1:0]  src_q,  src_eff;
    logic [MODE_W-1:0] mode_q, mode_eff;
    logic              mon_q,  mon_eff;
    logic              dly_q,  dly_eff;

    rcs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
        .clk  (clk),
        .arst (por_req),
        .din  (ext_rst_n),
        .dout (pin_sync)
    );

    assign ext_req = !pin_sync;
    assign req_any = ext_req || bor_req;

    // configuration follows the inputs while reset is held, frozen otherwise
    assign src_eff  = (state == ST_HOLD) ? cfg_src          : src_q;
    assign mode_eff = (state == ST_HOLD) ? cfg_pmode        : mode_q;
    assign mon_eff  = (state == ST_HOLD) ? cfg_monitor_en   : mon_q;
    assign dly_eff  = (state == ST_HOLD) ? cfg_pwrup_dly_en : dly_q;

    rcs_tick_cnt #(.LIMIT(PWRUP_TICKS)) u_pwrup_cnt (
        .clk  (clk),
        .arst (por_req),
        .clr  (cnt_clr),
        .tick (lprc_tick),
        .done (pwrup_done)
    );

    rcs_tick_cnt #(.LIMIT(OSC_EDGES)) u_osc_cnt (
        .clk  (clk),
        .arst (por_req),
        .clr  (cnt_clr),
        .tick (osc_edge),
        .done (osc_done)
    );

    rcs_fsm u_fsm (
        .clk         (clk),
        .arst        (por_req),
        .req_any     (req_any),
        .dly_en      (dly_eff),
        .mon_en      (mon_eff),
        .need_osc    (src_is_crystal(src_eff)),
        .need_pll    (mode_uses_pll(mode_eff)),
        .pwrup_done  (pwrup_done),
        .osc_done    (osc_done),
        .osc_running (osc_running),
        .pll_lock    (pll_lock),
        .state       (state),
        .trap        (clk_fail_trap),
        .rst_int     (rst_int),
        .sysclk_en   (sysclk_en),
        .fallback    (fallback),
        .cnt_clr     (cnt_clr)
    );

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            cause_q       <= CAUSE_POR;
            clk_fail_flag <= 1'b0;
            src_q         <= SRC_FAST_RC;
            mode_q        <= MODE_NONE;
            mon_q         <= 1'b0;
            dly_q         <= 1'b1;
        end else begin
            if (bor_req)      cause_q <= CAUSE_BOR;
            else if (ext_req) cause_q <= CAUSE_EXT;

            if (clk_fail_trap) clk_fail_flag <= 1'b1;
            else if (flag_clr) clk_fail_flag <= 1'b0;

            if (state == ST_HOLD) begin
                src_q  <= cfg_src;
                mode_q <= cfg_pmode;
                mon_q  <= cfg_monitor_en;
                dly_q  <= cfg_pwrup_dly_en;
            end
        end
    end

    assign clk_sel   = fallback ? SRC_FAST_RC : src_eff;
    assign clk_mode  = fallback ? MODE_NONE   : mode_eff;
    assign rst_cause = cause_q;

    assert_trap_sets_flag_R7: assert property (@(posedge clk) disable iff (por_req)
        clk_fail_trap |=> clk_fail_flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (por_req)
        (clk_fail_flag && !flag_clr) |=> clk_fail_flag);

    assert_ext_cause_R1: assert property (@(posedge clk) disable iff (por_req)
        (ext_req && !bor_req) |=> (rst_cause == CAUSE_EXT));

    assert_bor_cause_R1: assert property (@(posedge clk) disable iff (por_req)
        bor_req |=> (rst_cause == CAUSE_BOR));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (por_req)
        (state != ST_HOLD && $past(state) != ST_HOLD &&
         state != ST_FALLBACK && $past(state) != ST_FALLBACK) |-> $stable(clk_sel));

endmodule

// File: tb/rst_clk_seq_test.sv
module rst_clk_seq_test;

    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       bor_req = 1'b0;
    logic       lprc_tick = 1'b0;
    logic       osc_on = 1'b0;
    logic       pll_lock = 1'b0;
    logic [2:0] cfg_src = 3'b000;
    logic [4:0] cfg_pmode = 5'b00000;
    logic       cfg_monitor_en = 1'b0;
    logic       cfg_pwrup_dly_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       rst_int, sysclk_en, clk_fail_trap, clk_fail_flag;
    logic [2:0] clk_sel;
    logic [4:0] clk_mode;
    logic [1:0] rst_cause;

    int n_chk = 0;
    int n_bad = 0;
    int trap_seen = 0;
    int tdiv = 0;
    logic exp_flag = 1'b0;

    always #2 clk = ~clk;

    rst_clk_seq #(.PWRUP_TICKS(16), .OSC_EDGES(32)) uut (
        .clk              (clk),
        .por_req          (por_req),
        .ext_rst_n        (ext_rst_n),
        .bor_req          (bor_req),
        .lprc_tick        (lprc_tick),
        .osc_edge         (osc_on),
        .osc_running      (osc_on),
        .pll_lock         (pll_lock),
        .cfg_src          (cfg_src),
        .cfg_pmode        (cfg_pmode),
        .cfg_monitor_en   (cfg_monitor_en),
        .cfg_pwrup_dly_en (cfg_pwrup_dly_en),
        .flag_clr         (flag_clr),
        .rst_int          (rst_int),
        .sysclk_en        (sysclk_en),
        .clk_sel          (clk_sel),
        .clk_mode         (clk_mode),
        .clk_fail_trap    (clk_fail_trap),
        .clk_fail_flag    (clk_fail_flag),
        .rst_cause        (rst_cause)
    );

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        lprc_tick = (tdiv == 0);
        if (clk_fail_trap) trap_seen = trap_seen + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_fail(input logic [2:0] s, input logic [4:0] m, input logic mon,
                                      input logic dly, input logic osc_late, input logic lock_late);
        logic xtal_bad, pll_bad;
        xtal_bad = s[2] && (osc_late || !dly);
        pll_bad  = m[4] && lock_late;
        return mon && (xtal_bad || pll_bad);
    endfunction

    function automatic logic exp_gated(input logic [2:0] s, input logic [4:0] m,
                                       input logic osc_late, input logic lock_late);
        return (s[2] && osc_late) || (m[4] && lock_late);
    endfunction

    task automatic scen(input logic [2:0] s, input logic [4:0] m, input logic mon, input logic dly,
                        input logic osc_late, input logic lock_late, input logic clr);
        logic f;
        f = exp_fail(s, m, mon, dly, osc_late, lock_late);
        @(negedge clk);
        cfg_src = s; cfg_pmode = m; cfg_monitor_en = mon; cfg_pwrup_dly_en = dly;
        osc_on = !osc_late; pll_lock = !lock_late;
        flag_clr = clr; bor_req = 1'b1;
        if (clr) exp_flag = 1'b0;
        @(negedge clk); flag_clr = 1'b0;
        @(negedge clk);
        @(negedge clk); bor_req = 1'b0;
        trap_seen = 0;
        for (int t = 1; t <= 400; t++) begin
            @(negedge clk);
            if (t == 30) chk(dly ? "R3" : "R4", "rst_int early", rst_int, dly);
            if (t == 100) begin
                chk("R3", "rst_int after delay", rst_int, 0);
                if (f) begin
                    chk("R7", "fallback sysclk_en", sysclk_en, 1);
                    chk("R7", "fallback clk_sel", clk_sel, 0);
                end else if (exp_gated(s, m, osc_late, lock_late)) begin
                    chk("R6", "gated sysclk_en", sysclk_en, 0);
                end else begin
                    chk("R5", "ready sysclk_en", sysclk_en, 1);
                end
            end
            if (t == 150 && osc_late)  osc_on = 1'b1;
            if (t == 250 && lock_late) pll_lock = 1'b1;
        end
        exp_flag = exp_flag | f;
        chk("R6", "final rst_int", rst_int, 0);
        chk("R6", "final sysclk_en", sysclk_en, 1);
        chk(f ? "R7" : "R9", "final clk_sel", clk_sel, f ? 0 : s);
        chk(f ? "R7" : "R9", "final clk_mode", clk_mode, f ? 0 : m);
        chk("R7", "trap pulses", trap_seen, f ? 1 : 0);
        chk("R8", "flag", clk_fail_flag, exp_flag);
        chk("R1", "cause brown-out", rst_cause, 2'b11);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5A5A));
        // R1: power-on holds everything
        repeat (3) @(negedge clk);
        chk("R1", "por rst_int", rst_int, 1);
        chk("R1", "por sysclk_en", sysclk_en, 0);
        chk("R1", "por cause", rst_cause, 2'b01);
        chk("R8", "por flag", clk_fail_flag, 0);
        por_req = 1'b0;
        @(negedge clk);
        chk("R4", "release after por", rst_int, 0);
        @(negedge clk);
        chk("R5", "fast rc runs at once", sysclk_en, 1);

        // R2: pin synchroniser latency
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "pin edge 2", rst_int, 0);
        @(negedge clk);
        chk("R2", "pin edge 3", rst_int, 1);
        chk("R1", "cause pin", rst_cause, 2'b10);
        ext_rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "pin release edge 2", rst_int, 1);
        @(negedge clk);
        chk("R2", "pin release edge 3", rst_int, 0);

        // R4: brown-out release edge
        repeat (3) @(negedge clk);
        bor_req = 1'b1;
        @(negedge clk);
        chk("R1", "bor asserts reset", rst_int, 1);
        bor_req = 1'b0;
        @(negedge clk);
        chk("R4", "bor release edge 1", rst_int, 0);

        // R9: change outside reset ignored, loaded at next reset
        scen(3'b011, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        cfg_src = 3'b101;
        repeat (5) @(negedge clk);
        chk("R9", "cfg change ignored", clk_sel, 3'b011);
        scen(3'b101, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7/R8: fallback then flag survives a later brown-out
        scen(3'b100, 5'b10000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        scen(3'b000, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R8", "flag cleared", clk_fail_flag, 0);
        exp_flag = 1'b0;

        // directed: PLL late with monitor, crystal no delay with monitor
        scen(3'b010, 5'b10000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        scen(3'b110, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        scen(3'b111, 5'b10000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);

        for (int k = 0; k < 16; k++) begin
            logic [2:0] s;
            logic [4:0] m;
            s = 3'($urandom_range(0, 7));
            m = 5'($urandom_range(0, 31));
            scen(s, m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule